// File: doc/BRIEF.md
# Edge-Selectable Port Wakeup Interrupt Controller

This block watches a group of general-purpose input pins for a chosen transition on each one. Every pin has its own enable bit and its own edge-select bit, which pick either the rising or the falling edge. When the chosen edge arrives on an enabled pin, a sticky pending bit is set. One set of pending bits drives both outputs. While the core runs, any enabled pending bit raises a level interrupt request. While the core sleeps, the same condition raises a wakeup request instead.

The pins are asynchronous to the block clock. Each one passes through a multi-flop synchronizer before its edge is detected. Software reaches the pending bits only through an atomic swap. In the swap cycle the block returns the current pending contents and loads a replacement value that software supplies. An edge detected in that same cycle is merged into the new value, so the access cannot drop an edge. When software rewrites an edge-select bit, the detector history for that pin is reloaded. The change of polarity is therefore never taken as an edge.

Top module: `pin_wake_ctrl`

## Requirements
- R1: After reset, all enable bits, edge-select bits and pending bits are 0, and `irq` and `wake` are 0.
- R2: With edge-select bit 0 on an enabled pin, a low-to-high transition sets that pin's pending bit.
- R3: With edge-select bit 1 on an enabled pin, a high-to-low transition sets that pin's pending bit, and a low-to-high transition does not.
- R4: A transition on a pin whose enable bit is 0 leaves its pending bit unchanged.
- R5: A pending bit stays set until a swap writes 0 into it.
- R6: A swap (`swap_en`=1 for one cycle) returns the pending contents on `swap_rdata` in that cycle, and the pending register holds `swap_wdata` afterwards.
- R7: An edge detected in the same cycle as a swap is not returned by that swap, and its pending bit is set after the swap even though `swap_wdata` has 0 in that position.
- R8: `irq` is 1 exactly when `sleep`=0 and some pending bit has its enable bit set. `wake` is 1 under the same condition with `sleep`=1. The two outputs are never 1 together.
- R9: Rewriting the edge-select bits while the pins are stable sets no pending bit.
- R10: Configuration writes use `cfg_we`=1. `cfg_sel`=0 writes the enable register and `cfg_sel`=1 writes the edge-select register. Bit i of each register controls pin i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | N_PINS | Asynchronous port pins |
| sleep | input | 1 | 1 while the core is in sleep mode |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register select: 0 enable, 1 edge-select |
| cfg_wdata | input | N_PINS | Configuration write data |
| swap_en | input | 1 | Pending swap strobe |
| swap_wdata | input | N_PINS | Replacement pending value |
| swap_rdata | output | N_PINS | Pending contents before the swap |
| irq | output | 1 | Level interrupt request while awake |
| wake | output | 1 | Wakeup request while asleep |

## Verification
The assertions check several rules on every cycle. `irq` and `wake` are never 1 together, and each one follows the sleep state. Pending bits never clear without a swap. A swap always leaves its written bits set. A pending bit never rises on a disabled pin. Only the bench scenarios can show that the edge polarity is right, that the right pins are hit, that a swap returns the correct contents, and that an edge in the swap cycle survives. The scenarios also show that changing the edge-select bits raises nothing. These behaviours depend on the pin history that the bench itself models.

// File: rtl/pwk_pkg.sv
package pwk_pkg;
   typedef enum logic {
      CFG_ENABLE = 1'b0,
      CFG_EDGE   = 1'b1
   } cfg_reg_e;

   localparam int unsigned PWK_MAX_PINS = 32;
endpackage

// File: rtl/pwk_sync.sv
module pwk_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] stage_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pwk_edge.sv
module pwk_edge #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] smp,
   input  logic [WIDTH-1:0] pol,
   input  logic             pol_wr,
   input  logic [WIDTH-1:0] pol_nxt,
   output logic [WIDTH-1:0] hit
);
   // Polarity-normalised sample: the wanted edge is always 0 -> 1.
   logic [WIDTH-1:0] norm;
   logic [WIDTH-1:0] hist_q;

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      assign norm[i] = smp[i] ^ pol[i];
      assign hit[i]  = norm[i] & ~hist_q[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      hist_q[i] <= 1'b0;
         else if (pol_wr) hist_q[i] <= smp[i] ^ pol_nxt[i];
         else             hist_q[i] <= norm[i];
      end
   end
endmodule

// File: rtl/pwk_pend.sv
module pwk_pend #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_vec,
   input  logic             swap_en,
   input  logic [WIDTH-1:0] swap_wdata,
   output logic [WIDTH-1:0] pend_q
);
   logic [WIDTH-1:0] pend_d;

   always_comb begin
      if (swap_en) pend_d = swap_wdata | set_vec;
      else         pend_d = pend_q | set_vec;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_d;
   end
endmodule

// File: rtl/pin_wake_ctrl.sv
module pin_wake_ctrl
   import pwk_pkg::*;
#(
   parameter int unsigned N_PINS      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PINS-1:0] pin_in,
   input  logic              sleep,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [N_PINS-1:0] cfg_wdata,
   input  logic              swap_en,
   input  logic [N_PINS-1:0] swap_wdata,
   output logic [N_PINS-1:0] swap_rdata,
   output logic              irq,
   output logic              wake
);
   if (N_PINS < 1 || N_PINS > PWK_MAX_PINS) begin : g_bad_width
      $error("pin_wake_ctrl: N_PINS out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pin_wake_ctrl: SYNC_STAGES must be at least 2");
   end

   logic [N_PINS-1:0] en_q;
   logic [N_PINS-1:0] sel_q;
   logic [N_PINS-1:0] smp;
   logic [N_PINS-1:0] hit;
   logic [N_PINS-1:0] set_vec;
   logic [N_PINS-1:0] pend_q;
   logic              en_wr;
   logic              sel_wr;
   logic              req;

   assign en_wr  = cfg_we & (cfg_reg_e'(cfg_sel) == CFG_ENABLE);
   assign sel_wr = cfg_we & (cfg_reg_e'(cfg_sel) == CFG_EDGE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         sel_q <= '0;
      end else begin
         if (en_wr)  en_q  <= cfg_wdata;
         if (sel_wr) sel_q <= cfg_wdata;
      end
   end

   pwk_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (smp)
   );

   pwk_edge #(.WIDTH(N_PINS)) i_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .smp     (smp),
      .pol     (sel_q),
      .pol_wr  (sel_wr),
      .pol_nxt (cfg_wdata),
      .hit     (hit)
   );

   assign set_vec = hit & en_q;

   pwk_pend #(.WIDTH(N_PINS)) i_pend (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_vec    (set_vec),
      .swap_en    (swap_en),
      .swap_wdata (swap_wdata),
      .pend_q     (pend_q)
   );

   assign swap_rdata = pend_q;
   assign req        = |(pend_q & en_q);
   assign irq        = req & ~sleep;
   assign wake       = req & sleep;
endmodule

// File: rtl/pwk_chk.sv
module pwk_chk #(
   parameter int unsigned N = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         sleep,
   input logic         swap_en,
   input logic [N-1:0] swap_wdata,
   input logic         irq,
   input logic         wake,
   input logic [N-1:0] pend_q,
   input logic [N-1:0] en_q
);
   assert_exclusive_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq && wake));

   assert_irq_awake_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq || wake) |-> (irq == !sleep));

   assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(swap_en) |-> ((pend_q & $past(pend_q)) == $past(pend_q)));

   assert_swap_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(swap_en) |-> ((pend_q & $past(swap_wdata)) == $past(swap_wdata)));

   assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(swap_en) |-> ((pend_q & ~$past(pend_q) & ~$past(en_q)) == '0));
endmodule

bind pin_wake_ctrl pwk_chk #(.N(N_PINS)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sleep      (sleep),
   .swap_en    (swap_en),
   .swap_wdata (swap_wdata),
   .irq        (irq),
   .wake       (wake),
   .pend_q     (pend_q),
   .en_q       (en_q)
);

// File: tb/test_pin_wake_ctrl.sv
`timescale 1ns/1ps
module test_pin_wake_ctrl;
   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] pin_in = '0;
   logic         sleep = 1'b0;
   logic         cfg_we = 1'b0;
   logic         cfg_sel = 1'b0;
   logic [N-1:0] cfg_wdata = '0;
   logic         swap_en = 1'b0;
   logic [N-1:0] swap_wdata = '0;
   logic [N-1:0] swap_rdata;
   logic         irq;
   logic         wake;

   int n_chk = 0;
   int n_bad = 0;
   logic [N-1:0] m_en = '0, m_sel = '0, m_pend = '0;
   bit done = 0;

   always #4 clk = ~clk;

   pin_wake_ctrl #(.N_PINS(N)) i_pin_wake_ctrl (.*);

   function automatic logic [N-1:0] edge_hits(logic [N-1:0] o, logic [N-1:0] n,
                                              logic [N-1:0] en, logic [N-1:0] sel);
      return en & ((~sel & ~o & n) | (sel & o & ~n));
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cfg(logic s, logic [N-1:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
      if (s) m_sel = v; else m_en = v;
   endtask

   task automatic swap(logic [N-1:0] w, output logic [N-1:0] rd);
      @(negedge clk);
      swap_en = 1'b1; swap_wdata = w;
      #1 rd = swap_rdata;
      @(negedge clk);
      swap_en = 1'b0;
   endtask

   task automatic check_req(string req);
      logic r;
      r = |(m_pend & m_en);
      #1;
      check(req, {30'd0, irq, wake}, {30'd0, r & ~sleep, r & sleep});
   endtask

   initial begin
      #(8 * 200000);
      $display("FAIL watchdog: actual hung expected finish");
      n_chk++; n_bad++;
      done = 1;
   end

   initial begin : main
      logic [N-1:0] rd;
      logic [N-1:0] nv;
      void'($urandom(32'd1234));
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R1: reset state
      #1 check("R1 irq/wake", {30'd0, irq, wake}, 32'd0);
      check("R1 pending", swap_rdata, 0);
      // R1/R4: with reset enables, an edge is ignored
      pin_in = 8'hFF; idle(6);
      swap(8'h00, rd); check("R4 disabled after reset", rd, 0);

      // R2 rising on pin 3
      cfg(1'b0, 8'h08);
      pin_in = 8'hF7; idle(6);
      pin_in = 8'hFF; idle(6);
      m_pend = 8'h08;
      check_req("R8 irq awake");
      swap(8'h00, rd); check("R2 rising", rd, 8'h08); m_pend = 0;

      // R3 falling on pin 5 with edge-select 1; R9 no spurious set
      cfg(1'b0, 8'h20);
      cfg(1'b1, 8'h20); idle(5);
      swap(8'h00, rd); check("R9 select change", rd, 0);
      pin_in = 8'hDF; idle(6);
      swap(8'h00, rd); check("R3 falling", rd, 8'h20);
      pin_in = 8'hFF; idle(6);
      swap(8'h00, rd); check("R3 rising ignored", rd, 0);

      // R5 sticky, R8 wake while asleep
      pin_in = 8'hDF; idle(6); m_pend = 8'h20;
      sleep = 1'b1; idle(8);
      check_req("R8 wake asleep");
      swap(8'h20, rd); check("R5 sticky", rd, 8'h20);
      swap(8'h00, rd); check("R6 swap loads", rd, 8'h20); m_pend = 0;
      sleep = 1'b0;

      // R7 edge in the swap cycle: pin 5 rises back with select 0
      cfg(1'b1, 8'h00); idle(3);
      @(negedge clk); pin_in = 8'hFF;
      @(negedge clk);
      @(negedge clk);
      swap_en = 1'b1; swap_wdata = 8'h00;
      #1 rd = swap_rdata;
      @(negedge clk); swap_en = 1'b0;
      check("R7 not returned", rd, 0);
      swap(8'h00, rd); check("R7 kept", rd, 8'h20);
      m_pend = 0;

      // R10 / mixed random
      for (int it = 0; it < 300; it++) begin
         if ($urandom_range(3) == 0) begin
            cfg(1'($urandom_range(1)), N'($urandom));
            idle(3);
            if (($urandom_range(1) == 0)) begin
               swap(m_pend, rd); check("R9 R10 after config", rd, m_pend);
            end
         end
         nv = N'($urandom);
         m_pend |= edge_hits(pin_in, nv, m_en, m_sel);
         pin_in = nv;
         idle(5);
         sleep = 1'($urandom_range(1));
         check_req("R8 random");
         if ($urandom_range(1) == 0) begin
            logic [N-1:0] w;
            w = N'($urandom);
            swap(w, rd); check("R2 R3 R6 random", rd, m_pend);
            m_pend = w;
         end
      end
      done = 1;
   end

   initial begin
      wait (done);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule